// File: doc/BRIEF.md
# Dual-Channel Wiper Register Bank with Store Timer

This block holds the stored settings of two digital potentiometer channels. Each channel owns four 6-bit data registers kept in flops. A frame decoder in front of the block hands it one decoded command per serial frame, plus a single-cycle pulse when the frame closes on the chip-select rise. The block answers register reads and status reads, and it tells the wiper counters when to load a stored value. It also copies the current wiper positions into its registers when asked to.

Writes that stand for nonvolatile storage are only remembered when the command arrives. They are committed when the frame closes, and only if the write-protect input is high at that moment. A committed store raises a busy flag for a fixed number of clock cycles, set by a parameter, in place of the real store time. While the flag is up, the block refuses every command that would change a register or a wiper, but it still serves reads. Loads from a register into a wiper are volatile, so they take effect at once and never raise the busy flag.

Top module: `dpot_reg_bank`

## Requirements
- R1: Each channel has four 6-bit data registers that reset to 0. `cmd_reg` picks the register and `cmd_pot` picks the channel (0 or 1).
- R2: Opcodes on `cmd_op` are: 0 none, 1 read register, 2 write register, 3 read status, 4 register to wiper, 5 wiper to register, 6 global register to wiper, 7 global wiper to register. A read register command puts `{2'b00, value}` on `rd_data` one cycle later.
- R3: A write register command leaves the registers unchanged until `frame_end`. When the frame closes with the command pending, the new value is readable from the cycle after that `frame_end`.
- R4: A single wiper-to-register command captures the chosen channel's `wiper_i` value in the command cycle. On commit, it stores that value in the indexed register of that channel only.
- R5: A global wiper-to-register command stores both channels' wiper values, as captured in the command cycle, into the same register index of each channel.
- R6: A committed store drives `wip` high from the cycle after `frame_end` for exactly STORE_CYCLES cycles.
- R7: If `wp_n` is low at the `frame_end` that would commit, the pending store is dropped, `wip` stays low and no register changes.
- R8: A read status command puts `{7'b0, wip}` on `rd_data` one cycle later, with `wip` sampled in the command cycle. It is served even while `wip` is high.
- R9: A register-to-wiper command pulses `load_req` one cycle later for the chosen channel only. `load_val` of that channel then carries the register value, and `wip` does not rise.
- R10: A global register-to-wiper command pulses both `load_req` bits together. Each channel's `load_val` carries its own register at the shared index.
- R11: While `wip` is high, commands 2, 4, 5, 6 and 7 are ignored. They cause no load pulse and leave nothing for a later `frame_end` to commit.
- R12: A `frame_end` with no pending store changes nothing and leaves `wip` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: a decoded command is present |
| cmd_op | input | 3 | Operation code (see R2) |
| cmd_pot | input | 1 | Channel select |
| cmd_reg | input | 2 | Data register index |
| cmd_data | input | 6 | Write data from the host |
| frame_end | input | 1 | One-cycle pulse when the frame closes (chip-select rise) |
| wp_n | input | 1 | Write protect, active low |
| wiper_i | input | 2x6 | Current wiper position of each channel |
| rd_data | output | 8 | Read or status byte |
| load_req | output | 2 | Per-channel wiper load pulse |
| load_val | output | 2x6 | Per-channel value to load into the wiper |
| wip | output | 1 | Store in progress |

## Verification
The checker watches on every cycle that `wip` only rises after a frame close with write protect high, and that each busy window lasts exactly STORE_CYCLES cycles. It also checks the layout of the status byte, and that load pulses appear only for accepted commands, with the right number of bits set. The directed scenarios cover what depends on stored contents. This includes which register and channel a store touches, the wiper value captured at command time, and values dropped under write protect. It also covers the proof, read back afterwards, that commands given during a busy window left no trace.

// File: rtl/dpot_rb_pkg.sv
package dpot_rb_pkg;

    typedef enum logic [2:0] {
        OP_NONE             = 3'd0,
        OP_RD_REG           = 3'd1,
        OP_WR_REG           = 3'd2,
        OP_RD_STATUS        = 3'd3,
        OP_REG_TO_WIPER     = 3'd4,
        OP_WIPER_TO_REG     = 3'd5,
        OP_ALL_REG_TO_WIPER = 3'd6,
        OP_ALL_WIPER_TO_REG = 3'd7
    } rb_op_e;

endpackage

// File: rtl/rb_store_timer.sv
module rb_store_timer #(
    parameter int unsigned CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/rb_reg_file.sv
module rb_reg_file #(
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned DATA_W   = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  logic [$clog2(NUM_REGS)-1:0]   wr_idx_i,
    input  logic [DATA_W-1:0]             wr_data_i,
    input  logic [$clog2(NUM_REGS)-1:0]   rd_idx_i,
    output logic [DATA_W-1:0]             rd_data_o
);
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en_i) begin
            regs_d[wr_idx_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_data_o = regs_q[rd_idx_i];
endmodule

// File: rtl/dpot_reg_bank.sv
module dpot_reg_bank #(
    parameter int unsigned NUM_CH       = 2,
    parameter int unsigned NUM_REGS     = 4,
    parameter int unsigned DATA_W       = 6,
    parameter int unsigned RD_W         = 8,
    parameter int unsigned STORE_CYCLES = 1250000
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cmd_valid,
    input  logic [2:0]                        cmd_op,
    input  logic [$clog2(NUM_CH)-1:0]         cmd_pot,
    input  logic [$clog2(NUM_REGS)-1:0]       cmd_reg,
    input  logic [DATA_W-1:0]                 cmd_data,
    input  logic                              frame_end,
    input  logic                              wp_n,
    input  logic [NUM_CH-1:0][DATA_W-1:0]     wiper_i,
    output logic [RD_W-1:0]                   rd_data,
    output logic [NUM_CH-1:0]                 load_req,
    output logic [NUM_CH-1:0][DATA_W-1:0]     load_val,
    output logic                              wip
);
    import dpot_rb_pkg::*;

    localparam int unsigned CH_W  = $clog2(NUM_CH);
    localparam int unsigned IDX_W = $clog2(NUM_REGS);

    typedef struct packed {
        logic                          pend;
        logic                          pend_all;
        logic [CH_W-1:0]               pend_ch;
        logic [IDX_W-1:0]              pend_idx;
        logic [NUM_CH-1:0][DATA_W-1:0] pend_data;
        logic [RD_W-1:0]               rd;
        logic [NUM_CH-1:0]             load;
        logic [NUM_CH-1:0][DATA_W-1:0] load_val;
    } rb_state_t;

    rb_state_t s_d, s_q;

    logic                          busy;
    logic                          commit;
    logic                          accept;
    logic [NUM_CH-1:0]             wr_en;
    logic [NUM_CH-1:0][DATA_W-1:0] bank_rd;

    // A pending store is committed only at frame close, with protect released and no store running
    assign commit = frame_end && s_q.pend && wp_n && !busy;
    assign accept = cmd_valid && !busy;

    genvar ch;
    generate
        for (ch = 0; ch < NUM_CH; ch++) begin : g_chan
            assign wr_en[ch] = commit && (s_q.pend_all || (s_q.pend_ch == CH_W'(ch)));

            rb_reg_file #(
                .NUM_REGS (NUM_REGS),
                .DATA_W   (DATA_W)
            ) regs_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_en_i   (wr_en[ch]),
                .wr_idx_i  (s_q.pend_idx),
                .wr_data_i (s_q.pend_data[ch]),
                .rd_idx_i  (cmd_reg),
                .rd_data_o (bank_rd[ch])
            );
        end
    endgenerate

    rb_store_timer #(
        .CYCLES (STORE_CYCLES)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (commit),
        .busy_o  (busy)
    );

    always_comb begin
        s_d      = s_q;
        s_d.load = '0;
        if (frame_end) begin
            s_d.pend = 1'b0;
        end
        if (cmd_valid) begin
            case (rb_op_e'(cmd_op))
                OP_RD_REG: begin
                    s_d.rd = RD_W'(bank_rd[cmd_pot]);
                end
                OP_RD_STATUS: begin
                    s_d.rd = RD_W'(busy);
                end
                OP_WR_REG: begin
                    if (accept && !frame_end) begin
                        s_d.pend               = 1'b1;
                        s_d.pend_all           = 1'b0;
                        s_d.pend_ch            = cmd_pot;
                        s_d.pend_idx           = cmd_reg;
                        s_d.pend_data[cmd_pot] = cmd_data;
                    end
                end
                OP_WIPER_TO_REG: begin
                    if (accept && !frame_end) begin
                        s_d.pend               = 1'b1;
                        s_d.pend_all           = 1'b0;
                        s_d.pend_ch            = cmd_pot;
                        s_d.pend_idx           = cmd_reg;
                        s_d.pend_data[cmd_pot] = wiper_i[cmd_pot];
                    end
                end
                OP_ALL_WIPER_TO_REG: begin
                    if (accept && !frame_end) begin
                        s_d.pend      = 1'b1;
                        s_d.pend_all  = 1'b1;
                        s_d.pend_idx  = cmd_reg;
                        s_d.pend_data = wiper_i;
                    end
                end
                OP_REG_TO_WIPER: begin
                    if (accept) begin
                        s_d.load[cmd_pot]     = 1'b1;
                        s_d.load_val[cmd_pot] = bank_rd[cmd_pot];
                    end
                end
                OP_ALL_REG_TO_WIPER: begin
                    if (accept) begin
                        s_d.load     = '1;
                        s_d.load_val = bank_rd;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data  = s_q.rd;
    assign load_req = s_q.load;
    assign load_val = s_q.load_val;
    assign wip      = busy;
endmodule

// File: rtl/dpot_reg_bank_chk.sv
module dpot_reg_bank_chk #(
    parameter int unsigned NUM_CH       = 2,
    parameter int unsigned RD_W         = 8,
    parameter int unsigned STORE_CYCLES = 1250000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic              frame_end,
    input logic              wp_n,
    input logic [RD_W-1:0]   rd_data,
    input logic [NUM_CH-1:0] load_req,
    input logic              wip
);
    int unsigned run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 0;
        end else if (wip) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= 0;
        end
    end

    AST_WIP_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> ($past(frame_end) && $past(wp_n))); // R7

    AST_STORE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> (run_q == STORE_CYCLES)); // R6

    AST_STATUS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd3) |=> (rd_data == {{(RD_W-1){1'b0}}, $past(wip)})); // R8

    AST_LOAD_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (|load_req) |-> ($past(cmd_valid) && !$past(wip))); // R11

    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !wip && cmd_op == 3'd4) |=> ($countones(load_req) == 1)); // R9

    AST_LOAD_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !wip && cmd_op == 3'd6) |=> (&load_req)); // R10
endmodule

bind dpot_reg_bank dpot_reg_bank_chk #(
    .NUM_CH       (NUM_CH),
    .RD_W         (RD_W),
    .STORE_CYCLES (STORE_CYCLES)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .frame_end (frame_end),
    .wp_n      (wp_n),
    .rd_data   (rd_data),
    .load_req  (load_req),
    .wip       (wip)
);

// File: tb/dpot_reg_bank_tb_top.sv
module dpot_reg_bank_tb_top;
    localparam int unsigned STORE = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [2:0]      cmd_op = '0;
    logic            cmd_pot = 1'b0;
    logic [1:0]      cmd_reg = '0;
    logic [5:0]      cmd_data = '0;
    logic            frame_end = 1'b0;
    logic            wp_n = 1'b1;
    logic [1:0][5:0] wiper_i = '0;
    logic [7:0]      rd_data;
    logic [1:0]      load_req;
    logic [1:0][5:0] load_val;
    logic            wip;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    dpot_reg_bank #(.STORE_CYCLES(STORE)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_pot(cmd_pot), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
        .frame_end(frame_end), .wp_n(wp_n), .wiper_i(wiper_i),
        .rd_data(rd_data), .load_req(load_req), .load_val(load_val), .wip(wip)
    );

    always #4 clk = ~clk;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic issue(logic [2:0] op, logic pot, logic [1:0] idx, logic [5:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_pot = pot; cmd_reg = idx; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic close_frame();
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    task automatic read_reg(logic pot, logic [1:0] idx, output int val);
        issue(3'd1, pot, idx, 6'd0);
        val = rd_data;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (wip && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic t_reset();
        int v;
        check("R1 reset wip", wip, 0);
        check("R1 reset load_req", load_req, 0);
        check("R1 reset rd_data", rd_data, 0);
        for (int p = 0; p < 2; p++)
            for (int r = 0; r < 4; r++) begin
                read_reg(p[0], r[1:0], v);
                check("R1 R2 reset register", v, 0);
            end
    endtask

    task automatic t_write_store();
        int v;
        int n = 0;
        issue(3'd2, 1'b0, 2'd2, 6'h2A);
        read_reg(1'b0, 2'd2, v);
        check("R3 no change before frame end", v, 0);
        close_frame();
        while (wip && n < 100) begin n++; @(negedge clk); end
        check("R6 busy window length", n, STORE);
        read_reg(1'b0, 2'd2, v);
        check("R2 R3 stored value", v, 'h2A);
    endtask

    task automatic t_wiper_to_reg();
        int v;
        wiper_i = {6'h15, 6'h33};
        issue(3'd5, 1'b1, 2'd3, 6'd0);
        wiper_i = {6'h01, 6'h02};
        close_frame();
        wait_idle();
        read_reg(1'b1, 2'd3, v);
        check("R4 captured wiper stored", v, 'h15);
        read_reg(1'b0, 2'd3, v);
        check("R4 other channel untouched", v, 0);
    endtask

    task automatic t_global_store();
        int v;
        wiper_i = {6'h38, 6'h07};
        issue(3'd7, 1'b0, 2'd1, 6'd0);
        close_frame();
        wait_idle();
        read_reg(1'b0, 2'd1, v);
        check("R5 global store channel 0", v, 'h07);
        read_reg(1'b1, 2'd1, v);
        check("R5 global store channel 1", v, 'h38);
    endtask

    task automatic t_protect();
        int v;
        wp_n = 1'b0;
        issue(3'd2, 1'b0, 2'd0, 6'h3F);
        close_frame();
        check("R7 no busy under protect", wip, 0);
        wp_n = 1'b1;
        close_frame();
        check("R12 empty close leaves idle", wip, 0);
        read_reg(1'b0, 2'd0, v);
        check("R7 register unchanged", v, 0);
    endtask

    task automatic t_loads();
        issue(3'd4, 1'b0, 2'd2, 6'd0);
        check("R9 single load pulse", load_req, 'b01);
        check("R9 load value", load_val[0], 'h2A);
        check("R9 no busy", wip, 0);
        @(negedge clk);
        check("R9 pulse ends", load_req, 0);
        issue(3'd6, 1'b0, 2'd1, 6'd0);
        check("R10 global load pulse", load_req, 'b11);
        check("R10 value channel 0", load_val[0], 'h07);
        check("R10 value channel 1", load_val[1], 'h38);
    endtask

    task automatic t_busy_ignores();
        int v;
        issue(3'd2, 1'b1, 2'd0, 6'h0C);
        close_frame();
        issue(3'd3, 1'b0, 2'd0, 6'd0);
        check("R8 status while busy", rd_data, 1);
        issue(3'd4, 1'b1, 2'd3, 6'd0);
        check("R11 no load while busy", load_req, 0);
        issue(3'd2, 1'b0, 2'd3, 6'h01);
        close_frame();
        wait_idle();
        close_frame();
        check("R11 ignored write not committed later", wip, 0);
        read_reg(1'b0, 2'd3, v);
        check("R11 ignored write left register", v, 0);
        read_reg(1'b1, 2'd0, v);
        check("R3 accepted write stored", v, 'h0C);
        issue(3'd3, 1'b0, 2'd0, 6'd0);
        check("R8 status when idle", rd_data, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_store();
        t_wiper_to_reg();
        t_global_store();
        t_protect();
        t_loads();
        t_busy_ignores();
        close_frame();
        check("R12 stray close idle", wip, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule